// File: doc/BRIEF.md
# Prescaled 8-bit Compare Timer

This block is an 8-bit up-counter with a selectable rate divider and a single output-compare channel. A base tick feeds the divider. The base tick is either every system clock cycle or each rising edge of a slow tick input, and a source-select pin chooses between them. The slow input is synchronized and edge-detected inside the block. A 3-bit rate field either stops the counter or picks one of seven divide ratios.

Software reaches the counter and the compare value through a small register port. The counter and the compare value are checked for equality on every tick where the counter advances. A match sets a sticky flag, raises the interrupt output when enabled, and toggles the waveform pin. Writing the counter masks the compare check on the tick that follows the write. This allows the counter to be preloaded with the compare value without causing an immediate match.

Top module: `cmp_timer8`

## Requirements
- R1: After reset, reads of address 0 (counter), address 1 (compare) and address 2 (control) return 0, and `wave_out` and `irq` are 0.
- R2: With `rate_sel` = 0 the counter holds its value.
- R3: With `rate_sel` = 1..7 the counter advances once every 1, 8, 32, 64, 128, 256 or 1024 base ticks, in that order. The divide counter runs freely.
- R4: With `src_sel` = 1 each rising edge of `ext_tick` is one base tick, after a two-stage synchronizer. The divide counter restarts whenever `src_sel` changes, so 16 edges at `rate_sel` = 2 advance the counter by exactly 2.
- R5: Writes to address 0 and address 1 load the counter and the compare value. Reads return them one cycle after the address is presented. The counter wraps from 255 to 0.
- R6: On a tick where the counter, before advancing, equals the compare value, the match flag is set and `wave_out` toggles. Nothing else changes `wave_out`.
- R7: A write to the counter suppresses the compare check on the next tick, even when the written value equals the compare value.
- R8: Address 2 holds interrupt enable at bit 0 and the match flag at bit 1. Writing 1 to bit 1 clears the flag, and writing 0 leaves it set. A new match takes priority over the clear. `irq` equals flag AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Base tick source: 0 system clock, 1 ext_tick edges |
| rate_sel | input | 3 | 0 stop, 1..7 divide by 1/8/32/64/128/256/1024 |
| ext_tick | input | 1 | Slow asynchronous tick input |
| reg_addr | input | 2 | Register address: 0 counter, 1 compare, 2 control |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| wave_out | output | 1 | Waveform output, toggles per unmasked match |
| irq | output | 1 | Interrupt request |

## Verification
Each divide ratio is tried with the system clock as base. The bench measures the steady interval between counter changes, and this interval is independent of divider phase, so every tap position is separated from its neighbours. External ticks are driven at two ratios to show that edges, not levels, are counted and that the divider restarts on a source change. The compare channel is tested over short free runs with a counter preload. The cases are a compare value ahead of the preload, a compare value equal to the preload (masked), one that needs a wrap past 255, and one never reached. The match count is computed from the read-back advance. Flag writes with bit 1 at 0 and at 1, each with the enable on and off, separate stickiness, clearing and interrupt gating.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W  = 8;
  localparam int DIV_W  = 10;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CNT = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMP = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTL = 2'd2;

  // number of low divider bits that must be all ones for a divided tick
  function automatic int tap_shift(input logic [2:0] sel);
    case (sel)
      3'd1:    tap_shift = 0;
      3'd2:    tap_shift = 3;
      3'd3:    tap_shift = 5;
      3'd4:    tap_shift = 6;
      3'd5:    tap_shift = 7;
      3'd6:    tap_shift = 8;
      3'd7:    tap_shift = 10;
      default: tap_shift = 0;
    endcase
  endfunction
endpackage

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], din};
      last_q <= chain[STAGES-1];
    end
  end

  assign pulse = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/rate_divider.sv
module rate_divider
  import timer_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       src_sel,
  input  logic       base_en,
  input  logic [2:0] rate_sel,
  output logic       tick
);
  logic [W-1:0] div_q;
  logic         src_q;
  logic [W-1:0] tap_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      src_q <= 1'b0;
    end else begin
      src_q <= src_sel;
      if (src_sel != src_q) div_q <= '0;
      else if (base_en)     div_q <= div_q + 1'b1;
    end
  end

  always_comb begin
    tap_mask = '0;
    for (int i = 0; i < W; i++)
      if (i < tap_shift(rate_sel)) tap_mask[i] = 1'b1;
  end

  assign tick = base_en && (rate_sel != 3'd0) && ((div_q & tap_mask) == tap_mask);
endmodule

// File: rtl/count_compare.sv
module count_compare
  import timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_cnt,
  input  logic              wr_cmp,
  input  logic              wr_ctl,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      cnt_q,
  output logic [W-1:0]      cmp_q,
  output logic              flag_q,
  output logic              ie_q,
  output logic              wave_q,
  output logic              irq_q
);
  logic mask_q;
  logic match;
  logic flag_d;
  logic ie_d;

  assign match  = tick && !wr_cnt && !mask_q && (cnt_q == cmp_q);
  assign flag_d = match | (flag_q & ~(wr_ctl & wdata[1]));
  assign ie_d   = wr_ctl ? wdata[0] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      wave_q <= 1'b0;
      irq_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (wr_cnt)    cnt_q <= wdata;
      else if (tick) cnt_q <= cnt_q + 1'b1;
      if (wr_cnt)    mask_q <= 1'b1;
      else if (tick) mask_q <= 1'b0;
      if (wr_cmp)    cmp_q <= wdata;
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq_q  <= flag_d & ie_d;
      wave_q <= wave_q ^ match;
    end
  end
endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
  import timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_sel,
  input  logic [2:0]        rate_sel,
  input  logic              ext_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              wave_out,
  output logic              irq
);
  logic             ext_pulse;
  logic             base_en;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic             flag_q;
  logic             ie_q;
  logic             wr_cnt;
  logic             wr_cmp;
  logic             wr_ctl;

  assign wr_cnt  = reg_wr && (reg_addr == A_CNT);
  assign wr_cmp  = reg_wr && (reg_addr == A_CMP);
  assign wr_ctl  = reg_wr && (reg_addr == A_CTL);
  assign base_en = src_sel ? ext_pulse : 1'b1;

  tick_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ext_tick), .pulse(ext_pulse)
  );

  rate_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .src_sel(src_sel), .base_en(base_en),
    .rate_sel(rate_sel), .tick(tick)
  );

  count_compare #(.W(CNT_W)) u_cc (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_cnt(wr_cnt), .wr_cmp(wr_cmp), .wr_ctl(wr_ctl), .wdata(reg_wdata),
    .cnt_q(cnt_q), .cmp_q(cmp_q), .flag_q(flag_q), .ie_q(ie_q),
    .wave_q(wave_out), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_CNT:   reg_rdata <= cnt_q;
        A_CMP:   reg_rdata <= cmp_q;
        A_CTL:   reg_rdata <= {{(CNT_W-2){1'b0}}, flag_q, ie_q};
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cmp_timer8_checker.sv
module cmp_timer8_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] rate_sel,
  input logic       wr_cnt,
  input logic       wr_ctl,
  input logic [7:0] wdata,
  input logic [7:0] cnt_q,
  input logic       flag_q,
  input logic       ie_q,
  input logic       tick,
  input logic       ext_pulse,
  input logic       wave_out,
  input logic       irq
);
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == 3'd0 && !wr_cnt) |=> (cnt_q == $past(cnt_q))); // R2

  AST_DIV_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (rate_sel > 3'd1 && tick) |=> (!tick || rate_sel <= 3'd1)); // R3

  AST_EXT_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ext_pulse |=> !ext_pulse); // R4

  AST_WAVE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$stable(wave_out) |-> flag_q); // R6

  AST_WRITE_MASKS: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> $stable(wave_out)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_ctl && wdata[1])) |=> flag_q); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (ie_q && flag_q)); // R8
endmodule

bind cmp_timer8 cmp_timer8_checker u_chk (
  .clk(clk), .rst(rst), .rate_sel(rate_sel), .wr_cnt(wr_cnt), .wr_ctl(wr_ctl),
  .wdata(reg_wdata), .cnt_q(cnt_q), .flag_q(flag_q), .ie_q(ie_q),
  .tick(tick), .ext_pulse(ext_pulse), .wave_out(wave_out), .irq(irq)
);

// File: tb/test_cmp_timer8.sv
module test_cmp_timer8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       src_sel = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic       ext_tick = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       wave_out;
  logic       irq;

  int checks = 0;
  int failures = 0;
  int toggles = 0;
  logic prev_wave = 1'b0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  cmp_timer8 i_cmp_timer8 (
    .clk(clk), .rst(rst), .src_sel(src_sel), .rate_sel(rate_sel),
    .ext_tick(ext_tick), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wave_out(wave_out), .irq(irq)
  );

  always @(negedge clk) begin
    if (wave_out !== prev_wave) toggles++;
    prev_wave = wave_out;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic measure(input logic [2:0] sel, input int n);
    int last_t, cyc, seen;
    logic [7:0] prev;
    @(negedge clk);
    reg_addr = 2'd0;
    rate_sel = sel;
    @(negedge clk);
    prev = reg_rdata; cyc = 0; seen = 0; last_t = 0;
    while (seen < 4 && cyc < n * 6 + 50) begin
      @(negedge clk);
      cyc++;
      if (reg_rdata != prev) begin
        if (seen > 0) check($sformatf("R3 interval sel=%0d", sel), cyc - last_t, n);
        seen++; last_t = cyc; prev = reg_rdata;
      end
    end
    check($sformatf("R3 changes seen sel=%0d", sel), seen, 4);
    rate_sel = 3'd0;
  endtask

  task automatic ext_edges(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); ext_tick = 1'b1;
      repeat (4) @(negedge clk);
      ext_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic run_cmp(input string req, input logic [7:0] x, input logic [7:0] c, input int k);
    logic [7:0] v, t, d;
    int m;
    rate_sel = 3'd0;
    wr(2'd1, c);
    wr(2'd2, 8'h03);
    wr(2'd0, x);
    repeat (2) @(negedge clk);
    toggles = 0;
    rate_sel = 3'd1;
    repeat (k) @(negedge clk);
    rate_sel = 3'd0;
    repeat (3) @(negedge clk);
    rd(2'd0, v);
    t = v - x;
    d = c - x;
    m = (d >= 8'd1 && d < t) ? 1 : 0;
    check({req, " ticks"}, int'(t), k);
    check({req, " wave toggles"}, toggles, m);
    rd(2'd2, v);
    check({req, " flag"}, int'(v[1]), m);
    check({req, " irq"}, int'(irq), m);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(2'd0, rv); check("R1 counter reset", rv, 0);
    rd(2'd1, rv); check("R1 compare reset", rv, 0);
    rd(2'd2, rv); check("R1 control reset", rv, 0);
    check("R1 wave reset", int'(wave_out), 0);
    check("R1 irq reset", int'(irq), 0);

    wr(2'd0, 8'd77);
    repeat (100) @(negedge clk);
    rd(2'd0, rv); check("R2 stopped counter holds", rv, 77);
    wr(2'd1, 8'hA5);
    rd(2'd1, rv); check("R5 compare readback", rv, 8'hA5);
    wr(2'd1, 8'd0);

    measure(3'd1, 1);
    measure(3'd2, 8);
    measure(3'd3, 32);
    measure(3'd4, 64);
    measure(3'd5, 128);
    measure(3'd6, 256);
    measure(3'd7, 1024);

    // external source
    @(negedge clk); rate_sel = 3'd0; src_sel = 1'b1;
    repeat (5) @(negedge clk);
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd200);
    @(negedge clk); rate_sel = 3'd2;
    ext_edges(16);
    rate_sel = 3'd0;
    rd(2'd0, rv); check("R4 ext div8 16 edges", rv, 2);
    wr(2'd0, 8'd0);
    @(negedge clk); rate_sel = 3'd1;
    ext_edges(10);
    rate_sel = 3'd0;
    rd(2'd0, rv); check("R4 ext div1 10 edges", rv, 10);
    @(negedge clk); src_sel = 1'b0;
    repeat (3) @(negedge clk);

    // compare channel
    run_cmp("R6 match ahead", 8'd10, 8'd20, 30);
    // flag stickiness and clearing
    wr(2'd2, 8'h01);
    rd(2'd2, rv); check("R8 write0 keeps flag", rv, 3);
    check("R8 irq with enable", int'(irq), 1);
    wr(2'd2, 8'h00);
    rd(2'd2, rv); check("R8 enable off flag kept", rv, 2);
    check("R8 irq gated off", int'(irq), 0);
    wr(2'd2, 8'h02);
    rd(2'd2, rv); check("R8 write1 clears flag", rv, 0);

    run_cmp("R7 preload equals compare", 8'd40, 8'd40, 30);
    run_cmp("R5 wrap past 255", 8'd250, 8'd2, 12);
    run_cmp("R6 compare not reached", 8'd5, 8'd100, 20);
    run_cmp("R7 long run after mask", 8'd60, 8'd60, 200);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule